// File: doc/BRIEF.md
# Banked Register File Address Decoder

This block turns the operand address of a data-memory access into a physical target. The data space has four banks of 128 locations. In every bank the lowest 32 offsets hold special function registers and the rest holds general purpose RAM. An instruction supplies a 7-bit offset, and two bank bits pick the bank. When that offset is 00h, the access becomes indirect. The full address then comes from an 8-bit pointer register plus a separate high bank bit.

The decoder produces exactly one of three results. It can select one general purpose RAM word by a dense physical index. It can select one special register by a physical register index. Or it can select the zero source, which reads as 00h and absorbs writes. A small set of frequently used special registers is reachable from every bank, and all four bank views of each one land on the bank 0 copy. The RAM is packed densely into 363 words: banks 0 to 2 each hold 96 words and bank 3 holds 75. The decode is purely combinational, so the outputs follow the inputs within the same cycle.

Top module: `bfd_top`

## Requirements
- R1: When `dir_off` is not 00h, the access is direct: `ind_mode` is 0, the bank is `bank_sel` (00 gives bank 0, 01 bank 1, 10 bank 2, 11 bank 3) and the offset is `dir_off`.
- R2: When `dir_off` is 00h, the access is indirect: `ind_mode` is 1, the bank is {`irp`, `fsr[7]`}, the offset is `fsr[6:0]`, and `bank_sel` has no effect.
- R3: An effective offset from 01h to 1Fh asserts `sfr_sel`, and `sfr_idx` is {bank, offset[4:0]}, unless R4 applies.
- R4: Offsets 02h, 03h, 04h, 0Ah and 0Bh are mirrored. In every bank they give `sfr_idx` equal to the offset, which is the bank 0 copy.
- R5: In banks 0, 1 and 2, an effective offset from 20h to 7Fh asserts `ram_sel`, with `ram_idx` = bank*96 + offset - 20h.
- R6: In bank 3, offsets 20h to 6Ah assert `ram_sel` with `ram_idx` = 288 + offset - 20h. Offsets 6Bh to 7Fh assert `zero_sel` instead.
- R7: An indirect access whose effective offset is 00h asserts `zero_sel` and neither `ram_sel` nor `sfr_sel`. A read therefore returns zero and a write changes nothing.
- R8: Exactly one of `ram_sel`, `sfr_sel` and `zero_sel` is high for every input combination.
- R9: Across all addresses, each `ram_idx` value from 0 to 362 is produced by exactly one bank/offset pair, and no larger value is produced.
- R10: `ram_idx` is 0 whenever `ram_sel` is low, and `sfr_idx` is 0 whenever `sfr_sel` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dir_off | input | 7 | Direct operand offset from the instruction |
| bank_sel | input | 2 | Bank select bits for direct access |
| fsr | input | 8 | Pointer register value for indirect access |
| irp | input | 1 | High bank bit for indirect access |
| ind_mode | output | 1 | Access resolved through the pointer |
| ram_sel | output | 1 | General purpose RAM word selected |
| ram_idx | output | 9 | Dense physical RAM index |
| sfr_sel | output | 1 | Special function register selected |
| sfr_idx | output | 7 | Physical special register index |
| zero_sel | output | 1 | Reads zero, writes discarded |

## Verification
Two functions can act on the same access. Indirect redirection can point at a mirrored register in a high bank, so pointer resolution and mirror folding both apply. Indirect redirection can also point back at offset 00h, where it collides with the null-pointer rule. The bench sweeps every pointer value for both values of `irp`, with `bank_sel` set opposite to the resolved bank. Each result is compared with an arithmetic model, so a mirror fold applied to the wrong bank, or a null hit that leaks into the register select, shows up as a mismatch on that vector.

// File: rtl/bfd_pkg.sv
package bfd_pkg;
    localparam int OFF_W  = 7;
    localparam int BANK_W = 2;
    localparam int PTR_W  = OFF_W + 1;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [OFF_W-1:0]  off;
        logic              ind;
        logic              null_hit;
    } eff_addr_t;
endpackage

// File: rtl/bfd_addr_resolve.sv
module bfd_addr_resolve
    import bfd_pkg::*;
(
    input  logic [OFF_W-1:0]  dir_off,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [PTR_W-1:0]  fsr,
    input  logic              irp,
    output eff_addr_t         eff
);
    eff_addr_t eff_d;

    always_comb begin
        eff_d = '0;
        if (dir_off == '0) begin
            eff_d.ind      = 1'b1;
            eff_d.bank     = {irp, fsr[PTR_W-1]};
            eff_d.off      = fsr[OFF_W-1:0];
            eff_d.null_hit = (fsr[OFF_W-1:0] == '0);
        end else begin
            eff_d.bank     = bank_sel;
            eff_d.off      = dir_off;
        end
    end

    assign eff = eff_d;

    always_comb begin
        // R2
        indirect_bank_chk: assert (!eff.ind || eff.bank == {irp, fsr[PTR_W-1]})
            else $error("indirect bank not taken from pointer");
        // R7
        null_only_indirect_chk: assert (!eff.null_hit || (eff.ind && eff.off == '0))
            else $error("null hit outside indirect offset zero");
    end
endmodule

// File: rtl/bfd_region_decode.sv
module bfd_region_decode
    import bfd_pkg::*;
#(
    parameter int                SFR_SPAN      = 32,
    parameter int                BANK_SPAN     = 128,
    parameter int                LAST_BANK_GPR = 75,
    parameter logic [SFR_SPAN-1:0] MIRROR_MASK = 32'h0000_0C1C,
    parameter int                RAM_AW        = 9,
    parameter int                SFR_AW        = 5
) (
    input  eff_addr_t                 eff,
    output logic                      ram_sel,
    output logic [RAM_AW-1:0]         ram_idx,
    output logic                      sfr_sel,
    output logic [BANK_W+SFR_AW-1:0]  sfr_idx,
    output logic                      zero_sel
);
    localparam int GPR_PER_BANK = BANK_SPAN - SFR_SPAN;
    localparam int LAST_BANK    = (1 << BANK_W) - 1;

    typedef struct packed {
        logic                     ram;
        logic [RAM_AW-1:0]        ridx;
        logic                     sfr;
        logic [BANK_W+SFR_AW-1:0] sidx;
        logic                     zero;
    } region_t;

    region_t          reg_d;
    logic [OFF_W-1:0] gofs;

    always_comb begin
        reg_d = '0;
        gofs  = eff.off - OFF_W'(SFR_SPAN);
        if (eff.null_hit) begin
            reg_d.zero = 1'b1;
        end else if (eff.off < OFF_W'(SFR_SPAN)) begin
            reg_d.sfr = 1'b1;
            if (MIRROR_MASK[eff.off[SFR_AW-1:0]])
                reg_d.sidx = {{BANK_W{1'b0}}, eff.off[SFR_AW-1:0]};
            else
                reg_d.sidx = {eff.bank, eff.off[SFR_AW-1:0]};
        end else if (eff.bank == BANK_W'(LAST_BANK) && gofs >= OFF_W'(LAST_BANK_GPR)) begin
            reg_d.zero = 1'b1;
        end else begin
            reg_d.ram  = 1'b1;
            reg_d.ridx = RAM_AW'(eff.bank) * RAM_AW'(GPR_PER_BANK) + RAM_AW'(gofs);
        end
    end

    assign ram_sel  = reg_d.ram;
    assign ram_idx  = reg_d.ridx;
    assign sfr_sel  = reg_d.sfr;
    assign sfr_idx  = reg_d.sidx;
    assign zero_sel = reg_d.zero;

    always_comb begin
        // R3
        sfr_low_off_chk: assert (!sfr_sel || eff.off < OFF_W'(SFR_SPAN))
            else $error("register select above the special region");
        // R4
        mirror_fold_chk: assert (!(sfr_sel && MIRROR_MASK[eff.off[SFR_AW-1:0]])
                                 || sfr_idx[BANK_W+SFR_AW-1:SFR_AW] == '0)
            else $error("mirrored register not folded to bank 0");
        // R10
        idle_idx_chk: assert ((ram_sel || ram_idx == '0) && (sfr_sel || sfr_idx == '0))
            else $error("index driven while its select is low");
    end
endmodule

// File: rtl/bfd_top.sv
module bfd_top
    import bfd_pkg::*;
#(
    parameter int                  SFR_SPAN      = 32,
    parameter int                  LAST_BANK_GPR = 75,
    parameter logic [SFR_SPAN-1:0] MIRROR_MASK   = 32'h0000_0C1C
) (
    input  logic [6:0] dir_off,
    input  logic [1:0] bank_sel,
    input  logic [7:0] fsr,
    input  logic       irp,
    output logic       ind_mode,
    output logic       ram_sel,
    output logic [8:0] ram_idx,
    output logic       sfr_sel,
    output logic [6:0] sfr_idx,
    output logic       zero_sel
);
    localparam int BANK_SPAN = 1 << OFF_W;
    localparam int GPR_TOTAL = ((1 << BANK_W) - 1) * (BANK_SPAN - SFR_SPAN) + LAST_BANK_GPR;
    localparam int RAM_AW    = $clog2(GPR_TOTAL);
    localparam int SFR_AW    = $clog2(SFR_SPAN);

    eff_addr_t eff;

    bfd_addr_resolve u_resolve (
        .dir_off  (dir_off),
        .bank_sel (bank_sel),
        .fsr      (fsr),
        .irp      (irp),
        .eff      (eff)
    );

    bfd_region_decode #(
        .SFR_SPAN      (SFR_SPAN),
        .BANK_SPAN     (BANK_SPAN),
        .LAST_BANK_GPR (LAST_BANK_GPR),
        .MIRROR_MASK   (MIRROR_MASK),
        .RAM_AW        (RAM_AW),
        .SFR_AW        (SFR_AW)
    ) u_decode (
        .eff      (eff),
        .ram_sel  (ram_sel),
        .ram_idx  (ram_idx),
        .sfr_sel  (sfr_sel),
        .sfr_idx  (sfr_idx),
        .zero_sel (zero_sel)
    );

    assign ind_mode = eff.ind;

    always_comb begin
        // R8
        one_target_chk: assert ($countones({ram_sel, sfr_sel, zero_sel}) == 1)
            else $error("decoder did not pick exactly one target");
        // R9
        ram_bound_chk: assert (!ram_sel || int'(ram_idx) < GPR_TOTAL)
            else $error("RAM index beyond implemented words");
        // R1
        direct_mode_chk: assert ((dir_off == '0) == ind_mode)
            else $error("mode does not follow the direct offset");
    end
endmodule

// File: tb/bfd_top_tb_top.sv
module bfd_top_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [6:0] dir_off;
    logic [1:0] bank_sel;
    logic [7:0] fsr;
    logic       irp;
    logic       ind_mode, ram_sel, sfr_sel, zero_sel;
    logic [8:0] ram_idx;
    logic [6:0] sfr_idx;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    int hits [363];

    bfd_top dut_i (
        .dir_off (dir_off), .bank_sel (bank_sel), .fsr (fsr), .irp (irp),
        .ind_mode (ind_mode), .ram_sel (ram_sel), .ram_idx (ram_idx),
        .sfr_sel (sfr_sel), .sfr_idx (sfr_idx), .zero_sel (zero_sel)
    );

    function automatic bit is_mirror(input int o);
        return (o == 2 || o == 3 || o == 4 || o == 10 || o == 11);
    endfunction

    task automatic check_one(input int b, input int o, input bit ind, input string tag);
        bit e_ram = 0, e_sfr = 0, e_zero = 0;
        int e_ridx = 0, e_sidx = 0;
        string req;
        if (ind && o == 0) begin
            e_zero = 1; req = "R7";
        end else if (o < 32) begin
            e_sfr = 1;
            if (is_mirror(o)) begin e_sidx = o; req = "R4"; end
            else begin e_sidx = b * 32 + o; req = "R3"; end
        end else if (b == 3 && o - 32 >= 75) begin
            e_zero = 1; req = "R6";
        end else begin
            e_ram = 1; e_ridx = b * 96 + o - 32;
            req = (b == 3) ? "R6" : "R5";
        end
        @(negedge clk);
        total++;
        if (ind_mode !== ind || ram_sel !== e_ram || sfr_sel !== e_sfr || zero_sel !== e_zero ||
            int'(ram_idx) != e_ridx || int'(sfr_idx) != e_sidx) begin
            bad++;
            $display("FAIL %s/%s (R10 R8) bank=%0d off=%0h: got ind=%b r=%b ri=%0d s=%b si=%0d z=%b exp ind=%b r=%b ri=%0d s=%b si=%0d z=%b",
                     req, tag, b, o, ind_mode, ram_sel, ram_idx, sfr_sel, sfr_idx, zero_sel,
                     ind, e_ram, e_ridx, e_sfr, e_sidx, e_zero);
        end
        if (!ind && ram_sel === 1'b1 && int'(ram_idx) < 363) hits[ram_idx]++;
    endtask

    initial begin
        dir_off = '0; bank_sel = '0; fsr = '0; irp = 1'b0;
        foreach (hits[i]) hits[i] = 0;
        // reset-like idle state: indirect with null pointer (R7)
        check_one(0, 0, 1'b1, "idle");
        // R1 direct sweep over all banks and nonzero offsets
        for (int b = 0; b < 4; b++) begin
            for (int o = 1; o < 128; o++) begin
                dir_off = 7'(o); bank_sel = 2'(b); fsr = 8'hA5; irp = ~b[1];
                check_one(b, o, 1'b0, "R1");
            end
        end
        // R2 indirect sweep; bank_sel opposite of resolved bank
        for (int i = 0; i < 2; i++) begin
            for (int f = 0; f < 256; f++) begin
                dir_off = '0; irp = i[0]; fsr = 8'(f);
                bank_sel = ~{i[0], fsr[7]};
                check_one(i * 2 + f / 128, f % 128, 1'b1, "R2");
            end
        end
        // R9 each RAM word reached exactly once by direct addressing
        for (int k = 0; k < 363; k++) begin
            total++;
            if (hits[k] != 1) begin
                bad++;
                $display("FAIL R9 ram word %0d hit %0d times, expected 1", k, hits[k]);
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired: got running, expected done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule